// File: doc/BRIEF.md
# Descriptor Ring Receive Pointer Engine

This block keeps the books for one receive DMA channel whose buffers are described by a circular ring of descriptor tables. Every table holds the same programmable number of 128-bit entries. The engine fetches the entries of the table under its read pointer one at a time. While an entry is held, it offers that entry's destination address and byte length to the data path, and accepts one data beat that uses up the entry. The data path and the memory writes themselves lie outside the block.

A table is closed when its frame ends. That happens when the consumed entry is flagged as the table's last, when the data source marks the end of its data, or when the final configured entry has been used. Closing a table advances the read pointer, which carries a wrap toggle in its top bit, and sets a sticky end-of-frame status bit. Software owns a write pointer with the same wrap pattern and frees tables by moving it. The engine compares the two pointers to report an empty or full ring. It stops taking data while the ring is full. Status bits are cleared by writing ones to them.

Top module: `rxr_engine`

## Requirements
- R1: While reset is active, `rd_ptr_o` is 0, `ring_empty_o` is 1, `ring_full_o`, `eof_sts_o`, `cmp_sts_o`, `irq_o`, `desc_req_o` and `src_ready_o` are all 0.
- R2: The engine fetches entries in order, starting at entry 0 of the table given by the low 7 bits of the read pointer. `desc_req_o` stays high until `desc_vld_i` is seen, and the next entry is requested only after the current one is consumed.
- R3: While an entry is held, `src_ready_o` is 1, `wr_addr_o` equals descriptor bits 53:0 and `wr_len_o` equals descriptor bits 87:64. A beat (`src_valid_i` with `src_ready_o`) consumes the entry.
- R4: Consuming an entry whose bit 88 (end of table) is set closes the table.
- R5: Consuming an entry while `src_last_i` is high closes the table, even if bit 88 is clear.
- R6: Consuming entry number `cfg_ents_m1` closes the table, even without bit 88 or `src_last_i`.
- R7: Closing a table increments the read pointer index. When the index equals `cfg_depth_m1`, the index instead returns to 0 and bit 7 toggles. For depth 4 the sequence is 00,01,02,03,80,81,...
- R8: `ring_empty_o` is 1 exactly when `rd_ptr_o` equals `sw_wptr`.
- R9: `ring_full_o` is 1 when the low 7 bits of the two pointers match and bit 7 differs. While the ring is full, no descriptor is requested and no data is accepted.
- R10: Closing a table sets `eof_sts_o`. `irq_o` is `eof_sts_o` gated by `cfg_eof_ie`.
- R11: Consuming an entry whose bit 63 is set sets `cmp_sts_o`.
- R12: A 1 on `sts_clr[0]` clears `eof_sts_o` and a 1 on `sts_clr[1]` clears `cmp_sts_o`. If a set and a clear hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_depth_m1 | input | 7 | Ring depth minus one |
| cfg_ents_m1 | input | 8 | Entries per table minus one |
| cfg_eof_ie | input | 1 | End-of-frame interrupt enable |
| sw_wptr | input | 8 | Software write pointer (bit 7 wrap) |
| sts_clr | input | 2 | Write-one-to-clear: bit 0 end-of-frame, bit 1 completion |
| desc_req_o | output | 1 | Descriptor fetch request |
| desc_tbl_o | output | 7 | Table index of the request |
| desc_ent_o | output | 8 | Entry index of the request |
| desc_vld_i | input | 1 | Descriptor response valid |
| desc_data_i | input | 128 | Descriptor entry |
| src_valid_i | input | 1 | Data beat offered |
| src_last_i | input | 1 | Beat is the last of the data |
| src_ready_o | output | 1 | Beat accepted |
| wr_addr_o | output | 54 | Destination address of the held entry |
| wr_len_o | output | 24 | Byte length of the held entry |
| rd_ptr_o | output | 8 | Read pointer (bit 7 wrap) |
| ring_empty_o | output | 1 | Pointers equal |
| ring_full_o | output | 1 | Indices equal, wrap bits differ |
| eof_sts_o | output | 1 | Sticky end-of-frame status |
| cmp_sts_o | output | 1 | Sticky completion status |
| irq_o | output | 1 | Interrupt request |

## Verification
The collision case is a table closing in the same cycle as software clears `eof_sts_o`. The bench first clears the bit, then offers the closing beat with `sts_clr[0]` raised on the same clock. `eof_sts_o` must read 1 afterwards, and a later clear on its own must drop it. A second overlap is a single beat that both closes a table and carries bit 63. Both sticky bits must rise on that same edge, together with the pointer step.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int DESC_W   = 128;
  localparam int ADDR_W   = 54;
  localparam int LEN_W    = 24;
  localparam int ADDR_LSB = 0;
  localparam int IOC_BIT  = 63;
  localparam int LEN_LSB  = 64;
  localparam int EOT_BIT  = 88;
  localparam int NSTS     = 2;
  localparam int STS_EOF  = 0;
  localparam int STS_CMP  = 1;

  typedef enum logic [1:0] {
    W_IDLE  = 2'd0,
    W_FETCH = 2'd1,
    W_XFER  = 2'd2
  } walk_st_t;
endpackage

// File: rtl/rxr_ptr.sv
module rxr_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] depth_m1,
  input  logic [IDX_W:0]   wptr,
  input  logic             adv,
  output logic [IDX_W:0]   rptr,
  output logic             empty,
  output logic             full
);
  localparam logic [IDX_W-1:0] ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [IDX_W:0] rptr_n;
  logic [IDX_W-1:0] idx;
  logic             wrap;

  assign idx  = rptr[IDX_W-1:0];
  assign wrap = rptr[IDX_W];

  always_comb begin
    rptr_n = rptr;
    if (adv) begin
      if (idx == depth_m1) rptr_n = {~wrap, {IDX_W{1'b0}}};
      else                 rptr_n = {wrap, idx + ONE};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   rptr <= '0;
    else if (adv) rptr <= rptr_n;
  end

  assign empty = (rptr == wptr);
  assign full  = (idx == wptr[IDX_W-1:0]) && (wrap != wptr[IDX_W]);

  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(rptr)); // R7
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && idx == depth_m1) |=> (rptr[IDX_W] != $past(rptr[IDX_W])) && (rptr[IDX_W-1:0] == '0)); // R7
  AST_EMPTY_NOT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> !full); // R8
endmodule

// File: rtl/rxr_status.sv
module rxr_status #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] sts
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic nxt;
    logic en;
    assign en  = set[g] | clr[g];
    assign nxt = set[g] ? 1'b1 : 1'b0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  sts[g] <= 1'b0;
      else if (en) sts[g] <= nxt;
    end

    AST_STS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      set[g] |=> sts[g]); // R12
    AST_STS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[g] && !set[g]) |=> !sts[g]); // R12
    AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr[g] && sts[g]) |=> sts[g]); // R10
  end
endmodule

// File: rtl/rxr_walker.sv
module rxr_walker
  import rxr_pkg::*;
#(
  parameter int ENT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              full,
  input  logic [ENT_W-1:0]  ents_m1,
  output logic              desc_req,
  output logic [ENT_W-1:0]  desc_ent,
  input  logic              desc_vld,
  input  logic [DESC_W-1:0] desc_data,
  input  logic              src_valid,
  input  logic              src_last,
  output logic              src_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [LEN_W-1:0]  wr_len,
  output logic              retire,
  output logic              cmp_hit
);
  localparam logic [ENT_W-1:0] ONE = {{(ENT_W-1){1'b0}}, 1'b1};

  walk_st_t          st, st_n;
  logic [ENT_W-1:0]  ent, ent_n;
  logic              ent_en;
  logic              cap;
  logic              cur_ioc, cur_eot;
  logic              done;

  assign done = src_last | cur_eot | (ent == ents_m1);

  always_comb begin
    st_n      = st;
    ent_n     = ent;
    ent_en    = 1'b0;
    cap       = 1'b0;
    retire    = 1'b0;
    cmp_hit   = 1'b0;
    desc_req  = 1'b0;
    src_ready = 1'b0;
    case (st)
      W_IDLE:  if (!full) st_n = W_FETCH;
      W_FETCH: begin
        desc_req = 1'b1;
        if (desc_vld) begin
          cap  = 1'b1;
          st_n = W_XFER;
        end
      end
      W_XFER: begin
        src_ready = 1'b1;
        if (src_valid) begin
          cmp_hit = cur_ioc;
          ent_en  = 1'b1;
          if (done) begin
            retire = 1'b1;
            ent_n  = '0;
            st_n   = W_IDLE;
          end else begin
            ent_n  = ent + ONE;
            st_n   = W_FETCH;
          end
        end
      end
      default: st_n = W_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= W_IDLE;
    else        st <= st_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ent <= '0;
    else if (ent_en) ent <= ent_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_addr <= '0;
      wr_len  <= '0;
      cur_ioc <= 1'b0;
      cur_eot <= 1'b0;
    end else if (cap) begin
      wr_addr <= desc_data[ADDR_LSB +: ADDR_W];
      wr_len  <= desc_data[LEN_LSB +: LEN_W];
      cur_ioc <= desc_data[IOC_BIT];
      cur_eot <= desc_data[EOT_BIT];
    end
  end

  assign desc_ent = ent;

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (desc_req && !desc_vld) |=> desc_req); // R2
  AST_NO_FETCH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (st == W_IDLE && full) |=> !desc_req && !src_ready); // R9
  AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
    !(desc_req && src_ready)); // R2
  AST_ENT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (desc_ent == '0)); // R2
endmodule

// File: rtl/rxr_engine.sv
module rxr_engine
  import rxr_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int ENT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  cfg_depth_m1,
  input  logic [ENT_W-1:0]  cfg_ents_m1,
  input  logic              cfg_eof_ie,
  input  logic [IDX_W:0]    sw_wptr,
  input  logic [NSTS-1:0]   sts_clr,
  output logic              desc_req_o,
  output logic [IDX_W-1:0]  desc_tbl_o,
  output logic [ENT_W-1:0]  desc_ent_o,
  input  logic              desc_vld_i,
  input  logic [DESC_W-1:0] desc_data_i,
  input  logic              src_valid_i,
  input  logic              src_last_i,
  output logic              src_ready_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [LEN_W-1:0]  wr_len_o,
  output logic [IDX_W:0]    rd_ptr_o,
  output logic              ring_empty_o,
  output logic              ring_full_o,
  output logic              eof_sts_o,
  output logic              cmp_sts_o,
  output logic              irq_o
);
  logic [1:0]      rst_q;
  logic            rst_core_n;
  logic            retire, cmp_hit;
  logic [NSTS-1:0] sts_set, sts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 2'b00;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_core_n = rst_q[1];

  rxr_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .depth_m1 (cfg_depth_m1),
    .wptr     (sw_wptr),
    .adv      (retire),
    .rptr     (rd_ptr_o),
    .empty    (ring_empty_o),
    .full     (ring_full_o)
  );

  rxr_walker #(.ENT_W(ENT_W)) u_walk (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .full      (ring_full_o),
    .ents_m1   (cfg_ents_m1),
    .desc_req  (desc_req_o),
    .desc_ent  (desc_ent_o),
    .desc_vld  (desc_vld_i),
    .desc_data (desc_data_i),
    .src_valid (src_valid_i),
    .src_last  (src_last_i),
    .src_ready (src_ready_o),
    .wr_addr   (wr_addr_o),
    .wr_len    (wr_len_o),
    .retire    (retire),
    .cmp_hit   (cmp_hit)
  );

  always_comb begin
    sts_set          = '0;
    sts_set[STS_EOF] = retire;
    sts_set[STS_CMP] = cmp_hit;
  end

  rxr_status #(.N(NSTS)) u_sts (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (sts_set),
    .clr   (sts_clr),
    .sts   (sts)
  );

  assign desc_tbl_o = rd_ptr_o[IDX_W-1:0];
  assign eof_sts_o  = sts[STS_EOF];
  assign cmp_sts_o  = sts[STS_CMP];
  assign irq_o      = eof_sts_o & cfg_eof_ie;

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_core_n)
    irq_o |-> (eof_sts_o && cfg_eof_ie)); // R10
  AST_RETIRE_SETS_EOF: assert property (@(posedge clk) disable iff (!rst_core_n)
    (src_valid_i && src_ready_o && src_last_i) |=> eof_sts_o); // R5
endmodule

// File: tb/rxr_engine_test.sv
module rxr_engine_test;
  logic         clk = 1'b0;
  logic         rst_n;
  logic [6:0]   cfg_depth_m1;
  logic [7:0]   cfg_ents_m1;
  logic         cfg_eof_ie;
  logic [7:0]   sw_wptr;
  logic [1:0]   sts_clr;
  logic         desc_req_o;
  logic [6:0]   desc_tbl_o;
  logic [7:0]   desc_ent_o;
  logic         desc_vld_i;
  logic [127:0] desc_data_i;
  logic         src_valid_i, src_last_i, src_ready_o;
  logic [53:0]  wr_addr_o;
  logic [23:0]  wr_len_o;
  logic [7:0]   rd_ptr_o;
  logic         ring_empty_o, ring_full_o, eof_sts_o, cmp_sts_o, irq_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  rxr_engine uut (
    .clk(clk), .rst_n(rst_n), .cfg_depth_m1(cfg_depth_m1), .cfg_ents_m1(cfg_ents_m1),
    .cfg_eof_ie(cfg_eof_ie), .sw_wptr(sw_wptr), .sts_clr(sts_clr),
    .desc_req_o(desc_req_o), .desc_tbl_o(desc_tbl_o), .desc_ent_o(desc_ent_o),
    .desc_vld_i(desc_vld_i), .desc_data_i(desc_data_i), .src_valid_i(src_valid_i),
    .src_last_i(src_last_i), .src_ready_o(src_ready_o), .wr_addr_o(wr_addr_o),
    .wr_len_o(wr_len_o), .rd_ptr_o(rd_ptr_o), .ring_empty_o(ring_empty_o),
    .ring_full_o(ring_full_o), .eof_sts_o(eof_sts_o), .cmp_sts_o(cmp_sts_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step;
    @(posedge clk); #1;
  endtask

  function automatic logic [127:0] mk(input logic [53:0] a, input logic [23:0] l,
                                      input logic ioc, input logic eot);
    logic [127:0] d;
    d = '0;
    d[53:0]  = a;
    d[63]    = ioc;
    d[87:64] = l;
    d[88]    = eot;
    d[90:89] = 2'b11;
    return d;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] p, input logic [6:0] dm1);
    if (p[6:0] == dm1) return {~p[7], 7'd0};
    return {p[7], p[6:0] + 7'd1};
  endfunction

  logic [7:0] exp_ptr;

  // Serve one entry: wait for request, answer, then offer one beat.
  task automatic serve(input logic [7:0] ent, input logic [53:0] a, input logic [23:0] l,
                       input logic ioc, input logic eot, input logic last, input logic clr_eof);
    int n = 0;
    while (!desc_req_o && n < 50) begin step(); n++; end
    chk("R2 request seen", {63'd0, desc_req_o}, 64'd1);
    chk("R2 table index", {57'd0, desc_tbl_o}, {57'd0, exp_ptr[6:0]});
    chk("R2 entry index", {56'd0, desc_ent_o}, {56'd0, ent});
    desc_data_i = mk(a, l, ioc, eot);
    desc_vld_i  = 1'b1;
    step();
    desc_vld_i  = 1'b0;
    chk("R3 src_ready", {63'd0, src_ready_o}, 64'd1);
    chk("R3 wr_addr", {10'd0, wr_addr_o}, {10'd0, a});
    chk("R3 wr_len", {40'd0, wr_len_o}, {40'd0, l});
    src_valid_i = 1'b1;
    src_last_i  = last;
    sts_clr     = {1'b0, clr_eof};
    step();
    src_valid_i = 1'b0;
    src_last_i  = 1'b0;
    sts_clr     = 2'b00;
  endtask

  task automatic clear_all;
    sts_clr = 2'b11;
    step();
    sts_clr = 2'b00;
    chk("R12 eof cleared", {63'd0, eof_sts_o}, 64'd0);
    chk("R12 cmp cleared", {63'd0, cmp_sts_o}, 64'd0);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; cfg_depth_m1 = 7'd3; cfg_ents_m1 = 8'd3; cfg_eof_ie = 1'b1;
    sw_wptr = 8'h00; sts_clr = 2'b00; desc_vld_i = 1'b0; desc_data_i = '0;
    src_valid_i = 1'b0; src_last_i = 1'b0; exp_ptr = 8'h00;
    step(); step();
    chk("R1 rd_ptr", {56'd0, rd_ptr_o}, 64'd0);
    chk("R1 empty", {63'd0, ring_empty_o}, 64'd1);
    chk("R1 outs", {57'd0, ring_full_o, eof_sts_o, cmp_sts_o, irq_o, desc_req_o, src_ready_o, 1'b0}, 64'd0);
    rst_n = 1'b1;
    step();
  endtask

  task automatic t_eot;
    serve(8'd0, 54'h1000, 24'h0100, 1'b0, 1'b0, 1'b0, 1'b0);
    chk("R4 no retire without eot", {56'd0, rd_ptr_o}, {56'd0, exp_ptr});
    serve(8'd1, 54'h2000, 24'h0040, 1'b1, 1'b1, 1'b0, 1'b0);
    exp_ptr = nxt(exp_ptr, cfg_depth_m1);
    chk("R4 retire on eot", {56'd0, rd_ptr_o}, {56'd0, exp_ptr});
    chk("R10 eof set", {63'd0, eof_sts_o}, 64'd1);
    chk("R10 irq enabled", {63'd0, irq_o}, 64'd1);
    chk("R11 cmp set", {63'd0, cmp_sts_o}, 64'd1);
    chk("R8 not empty", {63'd0, ring_empty_o}, 64'd0);
    clear_all();
    chk("R10 irq drops", {63'd0, irq_o}, 64'd0);
  endtask

  task automatic t_last;
    cfg_eof_ie = 1'b0;
    serve(8'd0, 54'h3000, 24'h0010, 1'b0, 1'b0, 1'b1, 1'b0);
    exp_ptr = nxt(exp_ptr, cfg_depth_m1);
    chk("R5 retire on last", {56'd0, rd_ptr_o}, {56'd0, exp_ptr});
    chk("R10 eof set", {63'd0, eof_sts_o}, 64'd1);
    chk("R10 irq masked", {63'd0, irq_o}, 64'd0);
    clear_all();
    cfg_eof_ie = 1'b1;
  endtask

  task automatic t_exhaust;
    cfg_ents_m1 = 8'd1;
    serve(8'd0, 54'h4000, 24'h1000, 1'b0, 1'b0, 1'b0, 1'b0);
    serve(8'd1, 54'h5000, 24'h0800, 1'b0, 1'b0, 1'b0, 1'b0);
    exp_ptr = nxt(exp_ptr, cfg_depth_m1);
    chk("R6 retire on last entry", {56'd0, rd_ptr_o}, {56'd0, exp_ptr});
    chk("R11 cmp stays clear", {63'd0, cmp_sts_o}, 64'd0);
    clear_all();
  endtask

  task automatic t_wrap_full;
    serve(8'd0, 54'h6000, 24'h0020, 1'b0, 1'b1, 1'b0, 1'b0);
    exp_ptr = nxt(exp_ptr, cfg_depth_m1);
    chk("R7 wrap to 80", {56'd0, rd_ptr_o}, 64'h80);
    chk("R9 full", {63'd0, ring_full_o}, 64'd1);
    for (int i = 0; i < 8; i++) begin
      step();
      chk("R9 stalled", {62'd0, desc_req_o, src_ready_o}, 64'd0);
    end
    sw_wptr = 8'h80;
    #1;
    chk("R8 empty when equal", {63'd0, ring_empty_o}, 64'd1);
    chk("R9 not full", {63'd0, ring_full_o}, 64'd0);
    clear_all();
  endtask

  task automatic t_collide;
    serve(8'd0, 54'h7000, 24'h0004, 1'b1, 1'b1, 1'b0, 1'b1);
    exp_ptr = nxt(exp_ptr, cfg_depth_m1);
    chk("R7 step after wrap", {56'd0, rd_ptr_o}, 64'h81);
    chk("R12 set wins over clear", {63'd0, eof_sts_o}, 64'd1);
    chk("R11 cmp with eof", {63'd0, cmp_sts_o}, 64'd1);
    sts_clr = 2'b01;
    step();
    sts_clr = 2'b00;
    chk("R12 eof clear alone", {63'd0, eof_sts_o}, 64'd0);
    chk("R12 cmp untouched", {63'd0, cmp_sts_o}, 64'd1);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_eot();
    t_last();
    t_exhaust();
    t_wrap_full();
    t_collide();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule